// File: doc/BRIEF.md
# Banked Nibble-Register Calendar Timekeeper

This block is a calendar clock core. It holds the time of day, the weekday, the date and a four-digit year as packed decimal digits, with one digit in each 4-bit register. A once-per-second enable advances the time. The update handles hours, midnight, month lengths, leap years and the year digits.

Software reaches the registers over a small parallel bus. The bus has a 4-bit address, a 4-bit data path, a read strobe and a write strobe. The top address holds a control register that every bank can see.

Control register layout:
- Bit 0 reports a busy window.
- Bit 1 is a stop bit that freezes counting so a new time can be loaded.
- Bits 3:2 select the register bank.

Only bank 0 carries timekeeping digits. In any other bank, the digit addresses read as zero and ignore writes. Each accepted tick opens a busy window of a fixed length. Digit writes made during that window are held back and land when the window closes.

Top module: `nibble_rtc`

## Requirements
- R1: After a synchronous active-low reset, the time reads 2000-01-01 00:00:00 with weekday 0, and the control register reads 0. That means stop is 0, the bank is 0 and busy is 0.
- R2: Address 0xF is the control register in every bank. It reads as {bank[1:0], stop, busy} in bits 3:0. Writes to it set stop from bit 1 and the bank from bits 3:2. Bit 0 is read-only.
- R3: In bank 0, each address holds one BCD digit, as follows:

  | Address | Digit |
  |---|---|
  | 0x0 | seconds, units |
  | 0x1 | seconds, tens |
  | 0x2 | minutes, units |
  | 0x3 | minutes, tens |
  | 0x4 | hours, units |
  | 0x5 | hours, tens |
  | 0x6 | weekday |
  | 0x7 | day, units |
  | 0x8 | day, tens |
  | 0x9 | month (1 to 12), units |
  | 0xA | month, tens |
  | 0xB | year, units |
  | 0xC | year, tens |
  | 0xD | year, hundreds |
  | 0xE | year, thousands |

- R4: An accepted tick steps the seconds. Seconds and minutes wrap from 59 to 00 and carry onward. Hours wrap from 23 to 00, which advances the day. The weekday advances at each day change and wraps from 6 to 0.
- R5: The day wraps to 01 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. February has 28 days, or 29 in a leap year. A leap year is divisible by 4 and not by 100, unless it is divisible by 400. All other months have 31 days.
- R6: After day rollover, month 12 wraps to 1 and the four year digits increment as a decimal counter. Year 9999 wraps to 0000.
- R7: While stop is 1, ticks are ignored, so the digits hold and busy stays 0. Digit writes land directly on the next edge.
- R8: A tick accepted on clock edge E makes busy read 1 for the 4 cycles after E, from edge E+1 to edge E+4. Busy reads 0 from edge E+5, unless another tick arrives in the meantime.
- R9: A digit write made on an edge inside the busy window is deferred. This includes a write on the same edge as the tick. Only the most recent deferred write is kept, and it lands on the edge that closes the window. Until then, reads return the stepped time.
- R10: A read strobe on an edge captures the addressed register into the read data output, which then holds until the next read. In banks other than 0, the digit addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Registered read data |

## Verification
The calendar step is driven from loaded start points, each just short of a different carry boundary. These cover a minute boundary, an hour boundary, midnight with weekday wrap, 30-day and 31-day months, and February in common years, in a century year and in a 400-multiple year. They also cover the new-year boundary and the wrap of year 9999. Each start point separates one branch of the month-length or leap decision from its neighbours. Tick pulses are also sent while stopped, to separate a frozen chain from a running one. Writes are placed on the tick edge, inside the busy window and after it, to show the difference between direct, deferred and superseded writes. A behavioural model of the whole register space is compared with the read port on every clock.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
// Shared constants, the digit-record type and calendar helper functions
// for the nibble calendar timekeeper. Assumes one BCD digit per 4-bit register.
package rtc_pkg;

    localparam int          DIGITS    = 15;
    localparam int          NIB_W     = 4;
    localparam int          BANK_W    = 2;
    localparam logic [3:0]  CTRL_ADDR = 4'hF;
    localparam int          BUSY_BIT  = 0;
    localparam int          STOP_BIT  = 1;
    localparam int          BANK_LSB  = 2;

    typedef logic [NIB_W-1:0] nib_t;

    // Field order from MSB to LSB matches address 14 down to address 0.
    typedef struct packed {
        nib_t yr_k;
        nib_t yr_h;
        nib_t yr_t;
        nib_t yr_u;
        nib_t mo_t;
        nib_t mo_u;
        nib_t dy_t;
        nib_t dy_u;
        nib_t wday;
        nib_t hr_t;
        nib_t hr_u;
        nib_t mn_t;
        nib_t mn_u;
        nib_t sc_t;
        nib_t sc_u;
    } cal_t;

    // Reset image: 2000-01-01 00:00:00, weekday 0.
    localparam logic [DIGITS*NIB_W-1:0] CAL_RST = 60'h2000_0101_0000_000;

    // Last day of a BCD month, returned as two BCD digits.
    function automatic logic [7:0] last_day(input nib_t mt, input nib_t mu, input logic leap);
        logic [7:0] m;
        m = {mt, mu};
        case (m)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    endfunction

    // Leap test on four BCD digits; relies on 10 being 2 modulo 4.
    function automatic logic is_leap(input nib_t k, input nib_t h, input nib_t t, input nib_t u);
        logic [1:0] lo2;
        logic [1:0] hi2;
        lo2 = {t[0], 1'b0} + u[1:0];
        hi2 = {k[0], 1'b0} + h[1:0];
        is_leap = (lo2 == 2'b00) && (({t, u} != 8'h00) || (hi2 == 2'b00));
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
`timescale 1ns/1ps
// Combinational one-second step of the whole calendar record.
// Assumes the input digits form a valid date and time.
module rtc_cal_step
    import rtc_pkg::*;
(
    input  cal_t cur_i,
    output cal_t nxt_o
);

    logic       c_min;
    logic       c_hr;
    logic       c_day;
    logic       c_mon;
    logic       carry;
    logic       leap;
    logic [7:0] lastd;
    logic [15:0] yv;

    // Ripple the carries from seconds up to the year digits.
    always_comb begin
        nxt_o = cur_i;
        leap  = is_leap(cur_i.yr_k, cur_i.yr_h, cur_i.yr_t, cur_i.yr_u);
        lastd = last_day(cur_i.mo_t, cur_i.mo_u, leap);

        c_min = (cur_i.sc_u == 4'd9) && (cur_i.sc_t == 4'd5);
        c_hr  = c_min && (cur_i.mn_u == 4'd9) && (cur_i.mn_t == 4'd5);
        c_day = c_hr && (cur_i.hr_t == 4'd2) && (cur_i.hr_u == 4'd3);
        c_mon = c_day && ({cur_i.dy_t, cur_i.dy_u} == lastd);

        // seconds
        if (cur_i.sc_u == 4'd9) begin
            nxt_o.sc_u = 4'd0;
            nxt_o.sc_t = (cur_i.sc_t == 4'd5) ? 4'd0 : cur_i.sc_t + 4'd1;
        end else begin
            nxt_o.sc_u = cur_i.sc_u + 4'd1;
        end

        // minutes
        if (c_min) begin
            if (cur_i.mn_u == 4'd9) begin
                nxt_o.mn_u = 4'd0;
                nxt_o.mn_t = (cur_i.mn_t == 4'd5) ? 4'd0 : cur_i.mn_t + 4'd1;
            end else begin
                nxt_o.mn_u = cur_i.mn_u + 4'd1;
            end
        end

        // hours
        if (c_hr) begin
            if (c_day) begin
                nxt_o.hr_t = 4'd0;
                nxt_o.hr_u = 4'd0;
            end else if (cur_i.hr_u == 4'd9) begin
                nxt_o.hr_u = 4'd0;
                nxt_o.hr_t = cur_i.hr_t + 4'd1;
            end else begin
                nxt_o.hr_u = cur_i.hr_u + 4'd1;
            end
        end

        // weekday and day of month
        if (c_day) begin
            nxt_o.wday = (cur_i.wday == 4'd6) ? 4'd0 : cur_i.wday + 4'd1;
            if (c_mon) begin
                nxt_o.dy_t = 4'd0;
                nxt_o.dy_u = 4'd1;
            end else if (cur_i.dy_u == 4'd9) begin
                nxt_o.dy_u = 4'd0;
                nxt_o.dy_t = cur_i.dy_t + 4'd1;
            end else begin
                nxt_o.dy_u = cur_i.dy_u + 4'd1;
            end
        end

        // month
        carry = 1'b0;
        if (c_mon) begin
            if ({cur_i.mo_t, cur_i.mo_u} == 8'h12) begin
                nxt_o.mo_t = 4'd0;
                nxt_o.mo_u = 4'd1;
                carry      = 1'b1;
            end else if (cur_i.mo_u == 4'd9) begin
                nxt_o.mo_u = 4'd0;
                nxt_o.mo_t = 4'd1;
            end else begin
                nxt_o.mo_u = cur_i.mo_u + 4'd1;
            end
        end

        // four-digit decimal year counter
        yv = {cur_i.yr_k, cur_i.yr_h, cur_i.yr_t, cur_i.yr_u};
        for (int k = 0; k < 4; k++) begin
            if (carry) begin
                if (yv[4*k +: 4] == 4'd9) begin
                    yv[4*k +: 4] = 4'd0;
                end else begin
                    yv[4*k +: 4] = yv[4*k +: 4] + 4'd1;
                    carry        = 1'b0;
                end
            end
        end
        {nxt_o.yr_k, nxt_o.yr_h, nxt_o.yr_t, nxt_o.yr_u} = yv;
    end

endmodule

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
// Control register, busy window counter and deferred-write holding slot.
// Assumes BUSY_CYCLES >= 1 and one bus access per cycle.
module rtc_ctrl
    import rtc_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [3:0]        addr_i,
    input  logic [3:0]        wdata_i,
    output logic              stop_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              busy_o,
    output logic              step_o,
    output logic              we_o,
    output logic [3:0]        waddr_o,
    output logic [3:0]        wdata_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              stop_q;
    logic [BANK_W-1:0] bank_q;
    logic              pend_v_q;
    logic [3:0]        pend_a_q;
    logic [3:0]        pend_d_q;
    logic              ctrl_hit;
    logic              digit_hit;
    logic              in_window;
    logic              closing;

    assign ctrl_hit  = wr_i && (addr_i == CTRL_ADDR);
    assign digit_hit = wr_i && (addr_i != CTRL_ADDR) && (bank_q == '0);
    assign step_o    = tick_i && !stop_q;
    assign in_window = (cnt_q != '0) || step_o;
    assign closing   = (cnt_q == CNT_W'(1)) && !step_o;
    assign stop_o    = stop_q;
    assign bank_o    = bank_q;
    assign busy_o    = (cnt_q != '0);

    // Choose which digit write, if any, lands on this edge.
    always_comb begin
        we_o    = 1'b0;
        waddr_o = addr_i;
        wdata_o = wdata_i;
        if (digit_hit && !in_window) begin
            we_o = 1'b1;
        end else if (closing) begin
            if (digit_hit) begin
                we_o = 1'b1;
            end else if (pend_v_q) begin
                we_o    = 1'b1;
                waddr_o = pend_a_q;
                wdata_o = pend_d_q;
            end
        end
    end

    // Control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            bank_q <= '0;
        end else if (ctrl_hit) begin
            stop_q <= wdata_i[STOP_BIT];
            bank_q <= wdata_i[BANK_LSB +: BANK_W];
        end
    end

    // Busy window down-counter, restarted by each accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_o) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Holding slot for the latest digit write made inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q <= 1'b0;
            pend_a_q <= '0;
            pend_d_q <= '0;
        end else if (closing) begin
            pend_v_q <= 1'b0;
        end else if (digit_hit && in_window) begin
            pend_v_q <= 1'b1;
            pend_a_q <= addr_i;
            pend_d_q <= wdata_i;
        end
    end

endmodule

// File: rtl/rtc_digits.sv
`timescale 1ns/1ps
// Storage for the digit registers; a bus write wins over a calendar step.
// Assumes write and step never target the same edge in normal use.
module rtc_digits #(
    parameter int                    N     = 15,
    parameter logic [N*4-1:0]        RST_V = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_i,
    input  logic [N*4-1:0] next_i,
    input  logic           we_i,
    input  logic [3:0]     waddr_i,
    input  logic [3:0]     wdata_i,
    output logic [N*4-1:0] q_o
);

    for (genvar i = 0; i < N; i++) begin : g_dig
        // One digit: reset image, bus load, or stepped value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_o[4*i +: 4] <= RST_V[4*i +: 4];
            end else if (we_i && (waddr_i == 4'(i))) begin
                q_o[4*i +: 4] <= wdata_i;
            end else if (step_i) begin
                q_o[4*i +: 4] <= next_i[4*i +: 4];
            end
        end
    end

endmodule

// File: rtl/nibble_rtc.sv
`timescale 1ns/1ps
// Banked nibble-register calendar timekeeper: bus decode, read port,
// and wiring of control, calendar step and digit storage.
// Assumes tick_i is a single-cycle pulse synchronous to clk.
module nibble_rtc
    import rtc_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic [3:0] addr_i,
    input  logic [3:0] wdata_i,
    output logic [3:0] rdata_o
);

    logic                    stop_w;
    logic [BANK_W-1:0]       bank_w;
    logic                    busy_w;
    logic                    step_w;
    logic                    we_w;
    logic [3:0]              waddr_w;
    logic [3:0]              wdata_w;
    logic [DIGITS*4-1:0]     dig_q;
    cal_t                    nxt_w;
    logic [3:0]              rd_mux;

    rtc_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .stop_o  (stop_w),
        .bank_o  (bank_w),
        .busy_o  (busy_w),
        .step_o  (step_w),
        .we_o    (we_w),
        .waddr_o (waddr_w),
        .wdata_o (wdata_w)
    );

    rtc_cal_step u_step (
        .cur_i (cal_t'(dig_q)),
        .nxt_o (nxt_w)
    );

    rtc_digits #(.N(DIGITS), .RST_V(CAL_RST)) u_digits (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step_w),
        .next_i  (nxt_w),
        .we_i    (we_w),
        .waddr_i (waddr_w),
        .wdata_i (wdata_w),
        .q_o     (dig_q)
    );

    // Read selection: control in every bank, digits only in bank 0.
    always_comb begin
        if (addr_i == CTRL_ADDR) begin
            rd_mux = {bank_w, stop_w, busy_w};
        end else if (bank_w == '0) begin
            rd_mux = dig_q[{addr_i, 2'b00} +: 4];
        end else begin
            rd_mux = 4'd0;
        end
    end

    // Read data register, loaded on a read strobe and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= 4'd0;
        end else if (rd_i) begin
            rdata_o <= rd_mux;
        end
    end

endmodule

// File: rtl/nibble_rtc_chk.sv
`timescale 1ns/1ps
// Property checker bound to the timekeeper top.
module nibble_rtc_chk #(
    parameter int BUSY_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        rd_i,
    input logic        wr_i,
    input logic        stop_i,
    input logic        busy_i,
    input logic [59:0] digits_i,
    input logic [3:0]  rdata_i
);

    int run_q;

    // Length of the current busy run since the last accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (tick_i && !stop_i) begin
            run_q <= 0;
        end else if (busy_i) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_i && !wr_i) |=> $stable(digits_i));

    // R7
    stop_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_i) |=> !busy_i);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !stop_i) |=> busy_i);

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (run_q < BUSY_CYCLES));

    // R9
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !tick_i) |=> (!busy_i || $stable(digits_i)));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_i));

endmodule

bind nibble_rtc nibble_rtc_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .stop_i   (stop_w),
    .busy_i   (busy_w),
    .digits_i (dig_q),
    .rdata_i  (rdata_o)
);

// File: tb/nibble_rtc_bench.sv
`timescale 1ns/1ps
module nibble_rtc_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [3:0] addr_i = 4'd0;
    logic [3:0] wdata_i = 4'd0;
    logic [3:0] rdata_o;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    nibble_rtc u_nibble_rtc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .rd_i    (rd_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_d[15];
    int m_stop, m_bank, m_cnt, m_pv, m_pa, m_pdat, m_rdata;

    function automatic int mlen(int mo, int y);
        bit lp;
        lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int mread(int a);
        if (a == 15) return m_bank * 4 + m_stop * 2 + ((m_cnt != 0) ? 1 : 0);
        if (m_bank != 0) return 0;
        return m_d[a];
    endfunction

    task automatic m_advance();
        int s, mi, h, wd, d, mo, y;
        s  = m_d[1] * 10 + m_d[0];
        mi = m_d[3] * 10 + m_d[2];
        h  = m_d[5] * 10 + m_d[4];
        wd = m_d[6];
        d  = m_d[8] * 10 + m_d[7];
        mo = m_d[10] * 10 + m_d[9];
        y  = m_d[14] * 1000 + m_d[13] * 100 + m_d[12] * 10 + m_d[11];
        s++;
        if (s == 60) begin s = 0; mi++; end
        if (mi == 60) begin mi = 0; h++; end
        if (h == 24) begin
            h = 0; wd = (wd + 1) % 7;
            if (d == mlen(mo, y)) begin
                d = 1;
                if (mo == 12) begin mo = 1; y = (y + 1) % 10000; end
                else mo++;
            end else d++;
        end
        m_d[0] = s % 10;  m_d[1] = s / 10;
        m_d[2] = mi % 10; m_d[3] = mi / 10;
        m_d[4] = h % 10;  m_d[5] = h / 10;
        m_d[6] = wd;
        m_d[7] = d % 10;  m_d[8] = d / 10;
        m_d[9] = mo % 10; m_d[10] = mo / 10;
        m_d[11] = y % 10; m_d[12] = (y / 10) % 10;
        m_d[13] = (y / 100) % 10; m_d[14] = y / 1000;
    endtask

    // Model update on each rising edge from the inputs applied for that edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_d[i]) m_d[i] = 0;
            m_d[14] = 2; m_d[9] = 1; m_d[7] = 1;
            m_stop = 0; m_bank = 0; m_cnt = 0; m_pv = 0; m_pa = 0; m_pdat = 0; m_rdata = 0;
        end else begin
            automatic bit tk   = tick_i && (m_stop == 0);
            automatic bit dwin = (m_cnt != 0) || tk;
            automatic bit dwr  = wr_i && (addr_i != 4'hF) && (m_bank == 0);
            if (rd_i) m_rdata = mread(int'(addr_i));
            if (wr_i && addr_i == 4'hF) begin
                m_stop = int'(wdata_i[1]);
                m_bank = int'(wdata_i[3:2]);
            end
            if (tk) m_advance();
            if (dwr && !dwin) m_d[addr_i] = int'(wdata_i);
            else if (dwr) begin m_pv = 1; m_pa = int'(addr_i); m_pdat = int'(wdata_i); end
            if (tk) m_cnt = 4;
            else if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0 && m_pv != 0) begin m_d[m_pa] = m_pdat; m_pv = 0; end
            end
        end
    end

    // Cycle-by-cycle comparison of the read port against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rdata_o !== 4'(m_rdata)) begin
                fails++;
                $display("FAIL %s model compare: actual %0h expected %0h at %0t",
                         cur_req, rdata_o, m_rdata, $time);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic check(input logic [3:0] act, input int exp, input string req);
        checks++;
        if (act !== 4'(exp)) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr_i = 4'(a); wdata_i = 4'(d); wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        @(negedge clk);
        addr_i = 4'(a); rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        check(rdata_o, exp, req);
    endtask

    task automatic tick1();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic set_time(input int y, mo, d, h, mi, s, wd);
        wr(15, 2);
        wr(0, s % 10);  wr(1, s / 10);
        wr(2, mi % 10); wr(3, mi / 10);
        wr(4, h % 10);  wr(5, h / 10);
        wr(6, wd);
        wr(7, d % 10);  wr(8, d / 10);
        wr(9, mo % 10); wr(10, mo / 10);
        wr(11, y % 10); wr(12, (y / 10) % 10);
        wr(13, (y / 100) % 10); wr(14, y / 1000);
        wr(15, 0);
    endtask

    task automatic chk_time(input int y, mo, d, h, mi, s, wd, input string req);
        rd_chk(0, s % 10, req);  rd_chk(1, s / 10, req);
        rd_chk(2, mi % 10, req); rd_chk(3, mi / 10, req);
        rd_chk(4, h % 10, req);  rd_chk(5, h / 10, req);
        rd_chk(6, wd, req);
        rd_chk(7, d % 10, req);  rd_chk(8, d / 10, req);
        rd_chk(9, mo % 10, req); rd_chk(10, mo / 10, req);
        rd_chk(11, y % 10, req); rd_chk(12, (y / 10) % 10, req);
        rd_chk(13, (y / 100) % 10, req); rd_chk(14, y / 1000, req);
    endtask

    task automatic step_case(input int y, mo, d, h, mi, s, wd,
                             input int ey, emo, ed, eh, emi, es, ewd, input string req);
        cur_req = req;
        set_time(y, mo, d, h, mi, s, wd);
        tick1();
        chk_time(ey, emo, ed, eh, emi, es, ewd, req);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset image and R3 address map
        cur_req = "R1";
        chk_time(2000, 1, 1, 0, 0, 0, 0, "R1_R3");
        rd_chk(15, 0, "R1");

        // R4 seconds/minutes/hours carries and weekday wrap
        step_case(2021, 3, 14, 13, 59, 58, 2, 2021, 3, 14, 13, 59, 59, 2, "R4");
        tick1();
        chk_time(2021, 3, 14, 14, 0, 0, 2, "R4");
        step_case(2021, 3, 14, 23, 59, 59, 6, 2021, 3, 15, 0, 0, 0, 0, "R4");

        // R5 month lengths and leap rule
        step_case(2024, 2, 28, 23, 59, 59, 3, 2024, 2, 29, 0, 0, 0, 4, "R5");
        step_case(2024, 2, 29, 23, 59, 59, 4, 2024, 3, 1, 0, 0, 0, 5, "R5");
        step_case(2100, 2, 28, 23, 59, 59, 0, 2100, 3, 1, 0, 0, 0, 1, "R5");
        step_case(2000, 2, 28, 23, 59, 59, 1, 2000, 2, 29, 0, 0, 0, 2, "R5");
        step_case(2023, 2, 28, 23, 59, 59, 2, 2023, 3, 1, 0, 0, 0, 3, "R5");
        step_case(2021, 4, 30, 23, 59, 59, 5, 2021, 5, 1, 0, 0, 0, 6, "R5");
        step_case(2021, 1, 31, 23, 59, 59, 0, 2021, 2, 1, 0, 0, 0, 1, "R5");

        // R6 new year and year-digit wrap
        step_case(1999, 12, 31, 23, 59, 59, 5, 2000, 1, 1, 0, 0, 0, 6, "R6");
        step_case(9999, 12, 31, 23, 59, 59, 6, 0, 1, 1, 0, 0, 0, 0, "R6");

        // R7 stop freezes counting and busy stays low
        cur_req = "R7";
        set_time(2022, 6, 15, 8, 30, 10, 3);
        wr(15, 2);
        tick1(); tick1(); tick1();
        rd_chk(15, 2, "R7");
        chk_time(2022, 6, 15, 8, 30, 10, 3, "R7");
        wr(15, 0);

        // R8 busy window timing
        cur_req = "R8";
        @(negedge clk);
        tick_i = 1'b1; rd_i = 1'b1; addr_i = 4'hF;
        @(negedge clk);
        tick_i = 1'b0;
        check(rdata_o, 0, "R8 tick edge");
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check(rdata_o, (k <= 4) ? 1 : 0, "R8 window");
        end
        rd_i = 1'b0;
        chk_time(2022, 6, 15, 8, 30, 11, 3, "R8");

        // R9 deferred writes: only the latest in the window lands
        cur_req = "R9";
        set_time(2022, 6, 15, 10, 20, 30, 3);
        @(negedge clk);
        tick_i = 1'b1; wr_i = 1'b1; addr_i = 4'd0; wdata_i = 4'd7;
        @(negedge clk);
        tick_i = 1'b0; wr_i = 1'b0;
        @(negedge clk);
        wr_i = 1'b1; addr_i = 4'd2; wdata_i = 4'd5;
        @(negedge clk);
        wr_i = 1'b0; rd_i = 1'b1; addr_i = 4'd0;
        @(negedge clk);
        rd_i = 1'b0;
        check(rdata_o, 1, "R9 read during window");
        repeat (4) @(negedge clk);
        chk_time(2022, 6, 15, 10, 25, 31, 3, "R9");

        // R2 and R10 banks, control visibility, read-only busy bit
        cur_req = "R10";
        wr(15, 4);
        rd_chk(15, 4, "R2 bank1 ctrl");
        rd_chk(0, 0, "R10 bank1 digit");
        wr(0, 9);
        wr(15, 8);
        rd_chk(15, 8, "R2 bank2 ctrl");
        rd_chk(7, 0, "R10 bank2 digit");
        wr(15, 1);
        rd_chk(15, 0, "R2 busy read-only");
        rd_chk(0, 1, "R10 bank write ignored");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule